// File: doc/BRIEF.md
# Divide-by-Three Processor Clock Generator

This block derives a processor clock, a peripheral clock and a retimed reset from a fast reference. All logic runs on one reference clock. The source-select strap picks which of two advance qualifiers drives the dividers: the crystal-derived tick or the external-frequency tick. Every divider advance waits for a selected tick. The processor clock runs at one third of the selected tick rate and is high for one tick in three. The peripheral clock toggles on every processor-clock falling edge, which gives it half the processor rate and an even duty cycle.

A synchronous clock-sync input clears both dividers. Several generators that share that input therefore stay phase-aligned. The input must already be synchronous to the reference, and it acts only once it has been high for at least two reference cycles. When it is released, the next selected tick starts a high phase of the processor clock. The active-low reset request is sampled only at processor-clock falling edges. A one-reference-cycle strobe marks each of those falling edges, so downstream logic can act on them without a second clock domain.

Top module: `procclk_gen`

## Requirements
- R1: The processor clock goes high on the selected tick that follows phase zero. Over any run of continuous selected ticks, it is high in exactly one third of the cycles.
- R2: The processor clock stays high for exactly one selected tick and then stays low for the next two selected ticks.
- R3: The peripheral clock toggles at each processor-clock falling edge. Its period is six selected ticks and it is high for three of them.
- R4: With srcSel=0 only xtalTick advances the dividers, and with srcSel=1 only extTick does. A tick on the unselected input leaves every output unchanged.
- R5: While clkSync has been high for two or more consecutive reference cycles, procClk, periphClk and procClkFall are driven low and the divide phase returns to zero.
- R6: clkSync that is high for a single reference cycle has no effect on the divide sequence.
- R7: After clkSync falls, the first selected tick drives procClk high.
- R8: resetOut takes the inverse of resetReqN only at processor-clock falling edges. At all other times it holds.
- R9: procClkFall is high for exactly the one reference cycle that follows each counted processor-clock falling edge.
- R10: While rstN is low, procClk=0, periphClk=0, procClkFall=0 and resetOut=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock for all logic |
| rstN | input | 1 | Asynchronous active-low block reset |
| xtalTick | input | 1 | Advance qualifier from the crystal-derived source |
| extTick | input | 1 | Advance qualifier from the external-frequency source |
| srcSel | input | 1 | Source strap: 0 selects xtalTick, 1 selects extTick |
| clkSync | input | 1 | Synchronous divider clear, active high |
| resetReqN | input | 1 | Active-low reset request |
| procClk | output | 1 | Processor clock, one third rate, one-third duty |
| periphClk | output | 1 | Peripheral clock, half the processor rate, 50% duty |
| resetOut | output | 1 | Active-high reset, retimed to processor-clock falls |
| procClkFall | output | 1 | One-cycle strobe after each processor-clock fall |

## Verification
The bench targets the clear filter. A design that honoured a single-cycle clkSync pulse would restart the phase and hold procClk low where a high phase is due. A design that cleared one cycle late would let a counted falling edge escape during the second sync cycle. The bench also checks release alignment, so an off-by-one phase counter would delay the first high phase by a tick. It presents ticks on the unselected source, where a strap mux that leaked would advance the clocks. Finally, it changes the reset request during a high phase: a design that sampled it on every tick would move resetOut before the processor clock falls.

// File: rtl/procclk_pkg.sv
`timescale 1ns/1ps
package procclk_pkg;
  typedef struct packed {
    logic clear;  // qualified clock-sync: hold dividers at phase zero
    logic rise;   // processor clock enters its high phase
    logic fall;   // processor clock enters its low phase
  } clkStrobes_t;
endpackage

// File: rtl/procclk_ctrl.sv
`timescale 1ns/1ps
module procclk_ctrl
  import procclk_pkg::*;
#(
  parameter int DIV_RATIO  = 3,
  parameter int HIGH_TICKS = 1,
  parameter int SYNC_MIN   = 2
) (
  input  logic        refClk,
  input  logic        rstN,
  input  logic        xtalTick,
  input  logic        extTick,
  input  logic        srcSel,
  input  logic        clkSync,
  output clkStrobes_t strobes
);
  localparam int PW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam int SW = $clog2(SYNC_MIN + 1);
  localparam logic [PW-1:0] LAST_PHASE = PW'(DIV_RATIO - 1);
  localparam logic [PW-1:0] FALL_PHASE = PW'(HIGH_TICKS);
  localparam logic [SW-1:0] SYNC_LIMIT = SW'(SYNC_MIN - 1);

  logic [PW-1:0] phase;
  logic [SW-1:0] syncRun;
  logic          tickSel;
  logic          syncQualified;

  // strap mux ahead of the divider
  always_comb tickSel = srcSel ? extTick : xtalTick;

  // clear acts only after clkSync has been high long enough
  always_comb syncQualified = clkSync && (syncRun >= SYNC_LIMIT);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                     syncRun <= '0;
    else if (!clkSync)             syncRun <= '0;
    else if (syncRun < SYNC_LIMIT) syncRun <= syncRun + 1'b1;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)              phase <= '0;
    else if (syncQualified) phase <= '0;
    else if (tickSel)       phase <= (phase == LAST_PHASE) ? '0 : phase + 1'b1;
  end

  always_comb begin
    strobes.clear = syncQualified;
    strobes.rise  = tickSel && !syncQualified && (phase == '0);
    strobes.fall  = tickSel && !syncQualified && (phase == FALL_PHASE);
  end
endmodule

// File: rtl/procclk_datapath.sv
`timescale 1ns/1ps
module procclk_datapath
  import procclk_pkg::*;
(
  input  logic        refClk,
  input  logic        rstN,
  input  logic        resetReqN,
  input  clkStrobes_t strobes,
  output logic        procClk,
  output logic        periphClk,
  output logic        resetOut,
  output logic        procClkFall
);
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)              procClk <= 1'b0;
    else if (strobes.clear) procClk <= 1'b0;
    else if (strobes.rise)  procClk <= 1'b1;
    else if (strobes.fall)  procClk <= 1'b0;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)              periphClk <= 1'b0;
    else if (strobes.clear) periphClk <= 1'b0;
    else if (strobes.fall)  periphClk <= ~periphClk;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) procClkFall <= 1'b0;
    else       procClkFall <= strobes.fall;
  end

  // reset request captured only on processor clock falling edges
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)             resetOut <= 1'b1;
    else if (strobes.fall) resetOut <= ~resetReqN;
  end
endmodule

// File: rtl/procclk_gen.sv
`timescale 1ns/1ps
module procclk_gen
  import procclk_pkg::*;
#(
  parameter int DIV_RATIO  = 3,
  parameter int HIGH_TICKS = 1,
  parameter int SYNC_MIN   = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic xtalTick,
  input  logic extTick,
  input  logic srcSel,
  input  logic clkSync,
  input  logic resetReqN,
  output logic procClk,
  output logic periphClk,
  output logic resetOut,
  output logic procClkFall
);
  clkStrobes_t strobes;

  procclk_ctrl #(
    .DIV_RATIO (DIV_RATIO),
    .HIGH_TICKS(HIGH_TICKS),
    .SYNC_MIN  (SYNC_MIN)
  ) u_ctrl (
    .refClk  (refClk),
    .rstN    (rstN),
    .xtalTick(xtalTick),
    .extTick (extTick),
    .srcSel  (srcSel),
    .clkSync (clkSync),
    .strobes (strobes)
  );

  procclk_datapath u_dp (
    .refClk     (refClk),
    .rstN       (rstN),
    .resetReqN  (resetReqN),
    .strobes    (strobes),
    .procClk    (procClk),
    .periphClk  (periphClk),
    .resetOut   (resetOut),
    .procClkFall(procClkFall)
  );
endmodule

// File: rtl/procclk_checks.sv
`timescale 1ns/1ps
module procclk_checks (
  input logic refClk,
  input logic rstN,
  input logic xtalTick,
  input logic extTick,
  input logic srcSel,
  input logic clkSync,
  input logic procClk,
  input logic periphClk,
  input logic resetOut,
  input logic procClkFall
);
  logic tickSeen;
  always_comb tickSeen = srcSel ? extTick : xtalTick;

  AST_SYNC_CLEARS: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(rstN) && clkSync && $past(clkSync)) |=> (!procClk && !periphClk && !procClkFall)); // R5

  AST_HIGH_ONE_TICK: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(rstN) && $past(procClk) && $past(tickSeen)) |-> !procClk); // R2

  AST_FALL_STROBE: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(rstN) && procClkFall) |-> (!procClk && $past(procClk))); // R9

  AST_RESET_ON_FALL: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(rstN) && !$stable(resetOut)) |-> procClkFall); // R8

  AST_PERIPH_RISE: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(rstN) && $rose(periphClk)) |-> procClkFall); // R3

  AST_IDLE_HOLDS: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(rstN) && !$past(tickSeen) && !$past(clkSync)) |-> ($stable(procClk) && $stable(periphClk))); // R4
endmodule

bind procclk_gen procclk_checks u_checks (
  .refClk     (refClk),
  .rstN       (rstN),
  .xtalTick   (xtalTick),
  .extTick    (extTick),
  .srcSel     (srcSel),
  .clkSync    (clkSync),
  .procClk    (procClk),
  .periphClk  (periphClk),
  .resetOut   (resetOut),
  .procClkFall(procClkFall)
);

// File: tb/sim_procclk_gen.sv
`timescale 1ns/1ps
module sim_procclk_gen;
  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic xtalTick = 1'b0, extTick = 1'b0, srcSel = 1'b0, clkSync = 1'b0, resetReqN = 1'b1;
  logic procClk, periphClk, resetOut, procClkFall;
  int checks = 0;
  int errors = 0;

  always #10 refClk = ~refClk;

  procclk_gen u0 (
    .refClk(refClk), .rstN(rstN), .xtalTick(xtalTick), .extTick(extTick),
    .srcSel(srcSel), .clkSync(clkSync), .resetReqN(resetReqN),
    .procClk(procClk), .periphClk(periphClk), .resetOut(resetOut),
    .procClkFall(procClkFall)
  );

  // {xtalTick, extTick, srcSel, clkSync, resetReqN, procClk, periphClk, resetOut, procClkFall}
  localparam logic [8:0] VEC [0:13] = '{
    9'b10001_1010, // R1 rise from phase zero
    9'b10001_0101, // R2 R3 R8 R9 fall: periph up, reset released, strobe
    9'b10001_0100, // R2 second low tick
    9'b01001_0100, // R4 unselected ext tick ignored
    9'b10000_1100, // R8 request during high phase: resetOut holds
    9'b10000_0011, // R8 R3 captured at fall, periph down
    9'b01101_0010, // R4 ext source selected
    9'b01101_1010, // R1 rise on ext
    9'b01111_0101, // R6 first sync cycle not yet a clear
    9'b01111_0000, // R5 qualified clear
    9'b01111_0000, // R5 clear holds
    9'b01101_1000, // R7 first tick after release goes high
    9'b10101_1000, // R4 unselected xtal tick ignored
    9'b01101_0101  // R2 R9 fall after release
  };

  task automatic chk(input string req, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic step(input logic xt, input logic ex, input logic sel, input logic sy, input logic rq);
    xtalTick = xt; extTick = ex; srcSel = sel; clkSync = sy; resetReqN = rq;
    @(posedge refClk);
    @(negedge refClk);
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pcHigh, ppHigh, fsCount;
    logic prevPc;
    repeat (3) @(negedge refClk);
    chk("R10 procClk", procClk, 1'b0);
    chk("R10 periphClk", periphClk, 1'b0);
    chk("R10 resetOut", resetOut, 1'b1);
    chk("R10 procClkFall", procClkFall, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < 14; i++) begin
      step(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      chk($sformatf("R1-table row%0d procClk", i), procClk, VEC[i][3]);
      chk($sformatf("R3-table row%0d periphClk", i), periphClk, VEC[i][2]);
      chk($sformatf("R8-table row%0d resetOut", i), resetOut, VEC[i][1]);
      chk($sformatf("R9-table row%0d procClkFall", i), procClkFall, VEC[i][0]);
    end

    // realign with a qualified clear, then 30 continuous xtal ticks
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 1);
    chk("R5 cleared procClk", procClk, 1'b0);
    pcHigh = 0; ppHigh = 0; fsCount = 0; prevPc = procClk;
    for (int k = 0; k < 30; k++) begin
      step(1, 0, 0, 0, 1);
      if (procClk) pcHigh++;
      if (periphClk) ppHigh++;
      if (procClkFall) begin
        fsCount++;
        chk("R9 strobe follows fall", prevPc && !procClk, 1'b1);
      end
      prevPc = procClk;
    end
    chk("R1 one third high", pcHigh == 10, 1'b1);
    chk("R3 periph half duty", ppHigh == 15, 1'b1);
    chk("R9 strobe count", fsCount == 10, 1'b1);

    // single-cycle sync pulse at phase zero must not stop the rise
    step(1, 0, 0, 1, 1);
    chk("R6 single pulse ignored", procClk, 1'b1);
    step(1, 0, 0, 0, 1);
    chk("R6 sequence continues fall", procClkFall, 1'b1);

    // asynchronous block reset mid-run
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    rstN = 1'b0;
    #1;
    chk("R10 reset procClk", procClk, 1'b0);
    chk("R10 reset resetOut", resetOut, 1'b1);
    chk("R10 reset periphClk", periphClk, 1'b0);
    @(negedge refClk);
    rstN = 1'b1;
    step(1, 0, 0, 0, 1);
    chk("R1 rise after reset", procClk, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule